// File: doc/BRIEF.md
# Sine/Cosine Octant Reconstruction and Exception Stage

This stage is the last step of a dual sine/cosine operator. Upstream logic has already reduced the input angle and evaluated the sine and cosine of the reduced angle. This stage takes those two results, together with the octant index, the sign of the original input and the input's exception code. From them it forms the final sine and cosine of the original argument.

The two upper octant bits select a quadrant. The quadrant decides whether the two reduced results are swapped and which of them are negated. A negative input then flips the sign of the sine only, since cosine is even. Last, an override replaces both results whenever the input was zero, infinite or NaN. Both outputs are registered, so results appear one clock after the inputs.

Every operand and result is a word of EXP_W+MAN_W+3 bits. Its two top bits hold the exception code, the next bit holds the sign, and below that sit the exponent and then the mantissa.

Top module: `trig_recon_unit`

## Requirements
- R1: Word layout is, from the MSB down: a 2-bit exception code at [W-1:W-2], the sign at [W-3], an EXP_W-bit exponent, then an MAN_W-bit mantissa. The codes are 00 zero, 01 normal, 10 infinity and 11 NaN.
- R2: Both outputs are registered and reflect the inputs sampled at the previous rising clock edge. While rst_ni is low, both outputs are all-zero.
- R3: For a normal input with octant_i[2:1]=00 and sign_i=0, sin_o equals the reduced sine and cos_o equals the reduced cosine.
- R4: For octant_i[2:1]=01, sin_o equals the reduced cosine and cos_o equals the negated reduced sine.
- R5: For octant_i[2:1]=10, sin_o equals the negated reduced sine and cos_o equals the negated reduced cosine.
- R6: For octant_i[2:1]=11, sin_o equals the negated reduced cosine and cos_o equals the reduced sine.
- R7: octant_i[0] has no effect on either output.
- R8: sign_i=1 on a normal input inverts the sign bit of sin_o and leaves cos_o unchanged.
- R9: Negation inverts only the sign bit. The exception code, exponent and mantissa pass through unchanged, and a reduced value coded zero stays coded zero.
- R10: An input coded infinity or NaN makes both outputs a canonical NaN, with code 11 and sign, exponent and mantissa all zero, whatever the reduced inputs hold.
- R11: An input coded zero makes sin_o a zero (code 00, sign equal to sign_i, exponent and mantissa zero). It makes cos_o +1 (code 01, sign 0, exponent 2^(EXP_W-1)-1, mantissa 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sin_red_i | input | EXP_W+MAN_W+3 | Sine of the reduced angle |
| cos_red_i | input | EXP_W+MAN_W+3 | Cosine of the reduced angle |
| octant_i | input | 3 | Octant index from argument reduction |
| sign_i | input | 1 | Sign of the original input |
| exc_i | input | 2 | Exception code of the original input |
| sin_o | output | EXP_W+MAN_W+3 | Final sine |
| cos_o | output | EXP_W+MAN_W+3 | Final cosine |

## Verification
Every result passes through exactly one register, so each output is due at the first rising edge after its stimulus is applied. The bench drives a new stimulus on a falling edge and compares both outputs on the next falling edge. By then exactly one rising edge has passed, and the previous stimulus can no longer be visible. The checker's clocked properties use a one-cycle implication for the same reason.

// File: rtl/trig_recon_pkg.sv
package trig_recon_pkg;
  typedef enum logic [1:0] {
    EXC_ZERO = 2'b00,
    EXC_NORM = 2'b01,
    EXC_INF  = 2'b10,
    EXC_NAN  = 2'b11
  } exc_e;
endpackage

// File: rtl/trig_sign_flip.sv
module trig_sign_flip #(
  parameter int W = 34
) (
  input  logic [W-1:0] val_i,
  input  logic         flip_i,
  output logic [W-1:0] val_o
);
  localparam int SgnBit = W - 3;

  always_comb begin
    val_o         = val_i;
    val_o[SgnBit] = val_i[SgnBit] ^ flip_i;
  end
endmodule

// File: rtl/trig_octant_map.sv
module trig_octant_map #(
  parameter int W = 34
) (
  input  logic [W-1:0] sin_red_i,
  input  logic [W-1:0] cos_red_i,
  input  logic [1:0]   quad_i,
  input  logic         neg_in_i,
  output logic [W-1:0] sin_o,
  output logic [W-1:0] cos_o
);
  localparam int Lanes = 2;

  logic [W-1:0] lane_val [Lanes];
  logic         lane_neg [Lanes];
  logic [W-1:0] lane_res [Lanes];

  // lane 0 = sine, lane 1 = cosine
  always_comb begin
    unique case (quad_i)
      2'd0: begin
        lane_val[0] = sin_red_i; lane_neg[0] = 1'b0;
        lane_val[1] = cos_red_i; lane_neg[1] = 1'b0;
      end
      2'd1: begin
        lane_val[0] = cos_red_i; lane_neg[0] = 1'b0;
        lane_val[1] = sin_red_i; lane_neg[1] = 1'b1;
      end
      2'd2: begin
        lane_val[0] = sin_red_i; lane_neg[0] = 1'b1;
        lane_val[1] = cos_red_i; lane_neg[1] = 1'b1;
      end
      default: begin
        lane_val[0] = cos_red_i; lane_neg[0] = 1'b1;
        lane_val[1] = sin_red_i; lane_neg[1] = 1'b0;
      end
    endcase
    // odd function: input sign reaches the sine lane only
    lane_neg[0] = lane_neg[0] ^ neg_in_i;
  end

  for (genvar g = 0; g < Lanes; g++) begin : g_lane
    trig_sign_flip #(.W(W)) i_flip (
      .val_i  (lane_val[g]),
      .flip_i (lane_neg[g]),
      .val_o  (lane_res[g])
    );
  end

  assign sin_o = lane_res[0];
  assign cos_o = lane_res[1];
endmodule

// File: rtl/trig_exc_override.sv
module trig_exc_override
  import trig_recon_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [1:0]               exc_i,
  input  logic                     sign_i,
  input  logic [EXP_W+MAN_W+2:0]   sin_i,
  input  logic [EXP_W+MAN_W+2:0]   cos_i,
  output logic [EXP_W+MAN_W+2:0]   sin_o,
  output logic [EXP_W+MAN_W+2:0]   cos_o
);
  localparam int W = EXP_W + MAN_W + 3;
  localparam logic [EXP_W-1:0] Bias = EXP_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [W-1:0] NanWord = {EXC_NAN, 1'b0, {(EXP_W+MAN_W){1'b0}}};
  localparam logic [W-1:0] OneWord = {EXC_NORM, 1'b0, Bias, {MAN_W{1'b0}}};

  always_comb begin
    unique case (exc_i)
      EXC_ZERO: begin
        sin_o = {EXC_ZERO, sign_i, {(EXP_W+MAN_W){1'b0}}};
        cos_o = OneWord;
      end
      EXC_NORM: begin
        sin_o = sin_i;
        cos_o = cos_i;
      end
      default: begin
        sin_o = NanWord;
        cos_o = NanWord;
      end
    endcase
  end
endmodule

// File: rtl/trig_recon_unit.sv
module trig_recon_unit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [EXP_W+MAN_W+2:0] sin_red_i,
  input  logic [EXP_W+MAN_W+2:0] cos_red_i,
  input  logic [2:0]             octant_i,
  input  logic                   sign_i,
  input  logic [1:0]             exc_i,
  output logic [EXP_W+MAN_W+2:0] sin_o,
  output logic [EXP_W+MAN_W+2:0] cos_o
);
  localparam int W = EXP_W + MAN_W + 3;

  logic [W-1:0] sin_map, cos_map, sin_fin, cos_fin;

  trig_octant_map #(.W(W)) i_map (
    .sin_red_i (sin_red_i),
    .cos_red_i (cos_red_i),
    .quad_i    (octant_i[2:1]),
    .neg_in_i  (sign_i),
    .sin_o     (sin_map),
    .cos_o     (cos_map)
  );

  trig_exc_override #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_exc (
    .exc_i  (exc_i),
    .sign_i (sign_i),
    .sin_i  (sin_map),
    .cos_i  (cos_map),
    .sin_o  (sin_fin),
    .cos_o  (cos_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= sin_fin;
      cos_o <= cos_fin;
    end
  end
endmodule

// File: rtl/trig_recon_chk.sv
module trig_recon_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [EXP_W+MAN_W+2:0] sin_red_i,
  input logic [EXP_W+MAN_W+2:0] cos_red_i,
  input logic [2:0]             octant_i,
  input logic                   sign_i,
  input logic [1:0]             exc_i,
  input logic [EXP_W+MAN_W+2:0] sin_o,
  input logic [EXP_W+MAN_W+2:0] cos_o
);
  localparam int W = EXP_W + MAN_W + 3;
  localparam int S = W - 3;
  localparam logic [W-1:0] NanWord = {2'b11, {(W-2){1'b0}}};

  // R10
  inf_nan_gives_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i[1] |=> (sin_o == NanWord && cos_o == NanWord));

  // R11
  zero_gives_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i == 2'b00 |=> (cos_o[W-1:W-2] == 2'b01 && !cos_o[S] && cos_o[MAN_W-1:0] == '0
                        && sin_o[W-1:W-2] == 2'b00 && sin_o[S] == $past(sign_i)));

  // R3
  quad0_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i == 2'b01 && octant_i[2:1] == 2'b00 && !sign_i)
      |=> (sin_o == $past(sin_red_i) && cos_o == $past(cos_red_i)));

  // R8
  cos_sign_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i == 2'b01 && octant_i[2:1] == 2'b00) |=> (cos_o == $past(cos_red_i)));

  // R9
  neg_keeps_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i == 2'b01 && octant_i[2:1] == 2'b10)
      |=> (sin_o[W-1:W-2] == $past(sin_red_i[W-1:W-2])
           && sin_o[S-1:0] == $past(sin_red_i[S-1:0])
           && sin_o[S] == !$past(sin_red_i[S] ^ sign_i)));

  // R2
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (sin_o == '0 && cos_o == '0));
endmodule

bind trig_recon_unit trig_recon_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_trig_recon_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sin_red_i (sin_red_i),
  .cos_red_i (cos_red_i),
  .octant_i  (octant_i),
  .sign_i    (sign_i),
  .exc_i     (exc_i),
  .sin_o     (sin_o),
  .cos_o     (cos_o)
);

// File: tb/test_trig_recon_unit.sv
module test_trig_recon_unit;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int W = EXP_W + MAN_W + 3;
  localparam logic [EXP_W-1:0] BIAS = 8'd127;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] sin_red_i = '0, cos_red_i = '0;
  logic [2:0]   octant_i = '0;
  logic         sign_i = 1'b0;
  logic [1:0]   exc_i = 2'b01;
  logic [W-1:0] sin_o, cos_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  trig_recon_unit #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_trig_recon_unit (
    .clk_i, .rst_ni, .sin_red_i, .cos_red_i, .octant_i, .sign_i, .exc_i, .sin_o, .cos_o
  );

  function automatic logic [W-1:0] mk(logic [1:0] c, logic s, logic [EXP_W-1:0] e, logic [MAN_W-1:0] m);
    return {c, s, e, m};
  endfunction

  function automatic logic [W-1:0] neg(logic [W-1:0] v);
    return {v[W-1:W-2], ~v[W-3], v[W-4:0]};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, result due after the next rising edge
  task automatic apply(logic [W-1:0] s, logic [W-1:0] c, logic [2:0] k, logic sg, logic [1:0] ex);
    @(negedge clk_i);
    sin_red_i = s; cos_red_i = c; octant_i = k; sign_i = sg; exc_i = ex;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    apply(mk(2'b01, 1'b0, 8'd120, 23'h12345), mk(2'b01, 1'b0, 8'd126, 23'h7abcd), 3'd0, 1'b0, 2'b01);
    chk("R2 reset sin", sin_o, '0);
    chk("R2 reset cos", cos_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_quadrants(logic [W-1:0] s, logic [W-1:0] c);
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] es, ec;
      case (k >> 1)
        0: begin es = s;      ec = c;      end
        1: begin es = c;      ec = neg(s); end
        2: begin es = neg(s); ec = neg(c); end
        default: begin es = neg(c); ec = s; end
      endcase
      apply(s, c, 3'(k), 1'b0, 2'b01);
      // R3 R4 R5 R6 by quadrant; odd k covers R7
      chk((k >> 1) == 0 ? "R3 sin" : (k >> 1) == 1 ? "R4 sin" : (k >> 1) == 2 ? "R5 sin" : "R6 sin", sin_o, es);
      chk((k[0]) ? "R7 cos" : "R1 cos", cos_o, ec);
    end
  endtask

  task automatic t_sign();
    logic [W-1:0] s = mk(2'b01, 1'b0, 8'd119, 23'h0f0f0);
    logic [W-1:0] c = mk(2'b01, 1'b0, 8'd126, 23'h33333);
    apply(s, c, 3'd0, 1'b1, 2'b01);
    chk("R8 sin q0", sin_o, neg(s));
    chk("R8 cos q0", cos_o, c);
    apply(s, c, 3'd3, 1'b1, 2'b01);
    chk("R8 sin q1", sin_o, neg(c));
    chk("R8 cos q1", cos_o, neg(s));
    apply(s, c, 3'd6, 1'b1, 2'b01);
    chk("R8 sin q3", sin_o, c);
    chk("R8 cos q3", cos_o, s);
  endtask

  task automatic t_zero_reduced();
    logic [W-1:0] z = mk(2'b00, 1'b0, '0, '0);
    logic [W-1:0] one = mk(2'b01, 1'b0, BIAS, '0);
    apply(z, one, 3'd4, 1'b0, 2'b01);
    chk("R9 neg zero sin", sin_o, mk(2'b00, 1'b1, '0, '0));
    chk("R9 neg one cos", cos_o, mk(2'b01, 1'b1, BIAS, '0));
    apply(z, one, 3'd2, 1'b0, 2'b01);
    chk("R9 neg zero cos", cos_o, mk(2'b00, 1'b1, '0, '0));
  endtask

  task automatic t_exc();
    logic [W-1:0] s = mk(2'b01, 1'b1, 8'd100, 23'h55555);
    logic [W-1:0] c = mk(2'b01, 1'b0, 8'd126, 23'h2aaaa);
    logic [W-1:0] nan = mk(2'b11, 1'b0, '0, '0);
    apply(s, c, 3'd5, 1'b0, 2'b10);
    chk("R10 inf sin", sin_o, nan);
    chk("R10 inf cos", cos_o, nan);
    apply(s, c, 3'd1, 1'b1, 2'b11);
    chk("R10 nan sin", sin_o, nan);
    chk("R10 nan cos", cos_o, nan);
    apply(s, c, 3'd7, 1'b0, 2'b00);
    chk("R11 +0 sin", sin_o, mk(2'b00, 1'b0, '0, '0));
    chk("R11 +0 cos", cos_o, mk(2'b01, 1'b0, BIAS, '0));
    apply(s, c, 3'd2, 1'b1, 2'b00);
    chk("R11 -0 sin", sin_o, mk(2'b00, 1'b1, '0, '0));
    chk("R11 -0 cos", cos_o, mk(2'b01, 1'b0, BIAS, '0));
  endtask

  initial begin
    t_reset();
    t_quadrants(mk(2'b01, 1'b0, 8'd121, 23'h1a2b3), mk(2'b01, 1'b0, 8'd126, 23'h6c5d4));
    t_quadrants(mk(2'b01, 1'b1, 8'd90, 23'h7fffff), mk(2'b01, 1'b1, 8'd125, 23'h000001));
    t_sign();
    t_zero_reduced();
    t_exc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule